// File: doc/BRIEF.md
# Four-Instruction Accumulate Datapath

This block is a tiny arithmetic engine driven by a 2-bit opcode. Each cycle it may accept one instruction, together with two 8-bit operands. The instruction either sums or multiplies its operands. For two of the four codes, the second operand is replaced by the value the block produced last. The outcome is kept in a 16-bit result register, so a chain of instructions can build a running total or a running product. Fetching instructions, ordering them and writing results to memory all belong to the surrounding system.

Inside, a small decoder turns the opcode into two selector controls and a load strobe:
- The operand selector passes either the second input or the stored result.
- The result selector passes either the sum or the product.

Each selector passes its top input when its control is 0 and its bottom input when it is 1.

Top module: `accum_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes 0 and `resultValid` becomes 0, whatever the other inputs are.
- R2: Opcode 2'b00 with `inValid` high sets `result` to (`opA` + `opB`) at the next edge.
- R3: Opcode 2'b01 with `inValid` high sets `result` to (`opA` * `opB`) at the next edge.
- R4: Opcode 2'b10 with `inValid` high sets `result` to (`opA` + previous `result`) modulo 2^16 at the next edge. `opA` is zero-extended.
- R5: Opcode 2'b11 with `inValid` high sets `result` to (`opA` * previous `result`) modulo 2^16 at the next edge. `opA` is zero-extended.
- R6: A cycle with `inValid` low leaves `result` unchanged, whatever the opcode and operands are.
- R7: `resultValid` is high in exactly the cycle that follows each accepted instruction, and low after a cycle with `inValid` low.
- R8: An accumulate instruction issued first after reset takes 0 as the previous result. Opcode 2'b10 then yields `opA`, and opcode 2'b11 yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Instruction present this cycle |
| opcode | input | 2 | Machine code: bit 1 picks the stored result as second operand, bit 0 picks the product |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand (used by opcodes 00 and 01) |
| result | output | 16 | Result register |
| resultValid | output | 1 | High for one cycle after each accepted instruction |

## Verification
The tests use several kinds of input.

Directed operands at the extremes (0, 1 and 255) do two jobs:
- On the input-only opcodes they show that sums and products are kept to the full 16 bits.
- A run of accumulate steps pushed past 65535 shows that the wrap happens modulo 2^16. It also exposes an adder or multiplier that took the wrong selector input.

An accumulate issued right after each of two resets confirms that the stored value starts at zero.

A long seeded random stream mixes all four opcodes with idle cycles. Its idle cycles carry changing opcodes and operands. This separates a register that holds from one that loads regardless of the strobe. It also checks that the valid flag tracks each accepted instruction one cycle later.

// File: rtl/accum_pkg.sv
package accum_pkg;

  typedef enum logic [1:0] {
    OP_ADD_IN  = 2'b00,
    OP_MUL_IN  = 2'b01,
    OP_ADD_ACC = 2'b10,
    OP_MUL_ACC = 2'b11
  } opcode_e;

  typedef struct packed {
    logic load;        // accept this instruction
    logic selOperand;  // 0: second input, 1: previous result
    logic selProduct;  // 0: sum, 1: product
  } ctrlStrobes_t;

endpackage

// File: rtl/accum_sel2.sv
module accum_sel2 #(
  parameter int W = 16
) (
  input  logic         selBottom,
  input  logic [W-1:0] topIn,
  input  logic [W-1:0] bottomIn,
  output logic [W-1:0] outVal
);

  always_comb begin
    if (selBottom) outVal = bottomIn;
    else           outVal = topIn;
  end

endmodule

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
(
  input  logic         inValid,
  input  logic [1:0]   opcode,
  output ctrlStrobes_t strobes
);

  opcode_e opDec;

  assign opDec = opcode_e'(opcode);

  always_comb begin
    strobes.load = inValid;
    unique case (opDec)
      OP_ADD_IN:  begin strobes.selOperand = 1'b0; strobes.selProduct = 1'b0; end
      OP_MUL_IN:  begin strobes.selOperand = 1'b0; strobes.selProduct = 1'b1; end
      OP_ADD_ACC: begin strobes.selOperand = 1'b1; strobes.selProduct = 1'b0; end
      OP_MUL_ACC: begin strobes.selOperand = 1'b1; strobes.selProduct = 1'b1; end
      default:    begin strobes.selOperand = 1'b0; strobes.selProduct = 1'b0; end
    endcase
  end

endmodule

// File: rtl/accum_dp.sv
module accum_dp
  import accum_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic [RES_W-1:0] result,
  output logic             resultValid
);

  logic [RES_W-1:0] aWide;
  logic [RES_W-1:0] bWide;
  logic [RES_W-1:0] secondOp;
  logic [RES_W-1:0] sumVal;
  logic [RES_W-1:0] prodVal;
  logic [RES_W-1:0] nextVal;
  logic [RES_W-1:0] resultReg;
  logic             validReg;

  assign aWide = RES_W'(opA);
  assign bWide = RES_W'(opB);

  accum_sel2 #(.W(RES_W)) u_selOperand (
    .selBottom (strobes.selOperand),
    .topIn     (bWide),
    .bottomIn  (resultReg),
    .outVal    (secondOp)
  );

  assign sumVal  = aWide + secondOp;
  assign prodVal = aWide * secondOp;

  accum_sel2 #(.W(RES_W)) u_selResult (
    .selBottom (strobes.selProduct),
    .topIn     (sumVal),
    .bottomIn  (prodVal),
    .outVal    (nextVal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resultReg <= '0;
      validReg  <= 1'b0;
    end else begin
      validReg <= strobes.load;
      if (strobes.load) resultReg <= nextVal;
    end
  end

  assign result      = resultReg;
  assign resultValid = validReg;

endmodule

// File: rtl/accum_unit.sv
module accum_unit
  import accum_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int RES_W = 2 * OP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [1:0]       opcode,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic [RES_W-1:0] result,
  output logic             resultValid
);

  ctrlStrobes_t strobes;

  accum_ctrl u_ctrl (
    .inValid (inValid),
    .opcode  (opcode),
    .strobes (strobes)
  );

  accum_dp #(.OP_W(OP_W), .RES_W(RES_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .opA         (opA),
    .opB         (opB),
    .result      (result),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/accum_unit_chk.sv
module accum_unit_chk #(
  parameter int OP_W  = 8,
  parameter int RES_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [1:0]       opcode,
  input logic [OP_W-1:0]  opA,
  input logic [OP_W-1:0]  opB,
  input logic [RES_W-1:0] result,
  input logic             resultValid
);

  logic [RES_W-1:0] aW;
  logic [RES_W-1:0] bW;
  assign aW = RES_W'(opA);
  assign bW = RES_W'(opB);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (result == '0) && !resultValid); // R1
  AST_ADD_INPUTS: assert property (@(posedge clk) disable iff (rst)
    (inValid && opcode == 2'b00) |=> result == ($past(aW) + $past(bW))); // R2
  AST_MUL_INPUTS: assert property (@(posedge clk) disable iff (rst)
    (inValid && opcode == 2'b01) |=> result == ($past(aW) * $past(bW))); // R3
  AST_ADD_PREV: assert property (@(posedge clk) disable iff (rst)
    (inValid && opcode == 2'b10) |=> result == ($past(aW) + $past(result))); // R4
  AST_MUL_PREV: assert property (@(posedge clk) disable iff (rst)
    (inValid && opcode == 2'b11) |=> result == ($past(aW) * $past(result))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result)); // R6
  AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
    inValid |=> resultValid); // R7
  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !resultValid); // R7

endmodule

bind accum_unit accum_unit_chk #(.OP_W(OP_W), .RES_W(RES_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .inValid     (inValid),
  .opcode      (opcode),
  .opA         (opA),
  .opB         (opB),
  .result      (result),
  .resultValid (resultValid)
);

// File: tb/accum_unit_bench.sv
`timescale 1ns/1ps
module accum_unit_bench;

  localparam int OP_W  = 8;
  localparam int RES_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inValid = 1'b0;
  logic [1:0]       opcode = 2'b00;
  logic [OP_W-1:0]  opA = '0;
  logic [OP_W-1:0]  opB = '0;
  logic [RES_W-1:0] result;
  logic             resultValid;

  int testsRun = 0;
  int testsFailed = 0;
  logic [RES_W-1:0] expRes = '0;

  always #4 clk = ~clk;

  accum_unit #(.OP_W(OP_W), .RES_W(RES_W)) u_accum_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .opcode(opcode),
    .opA(opA), .opB(opB), .result(result), .resultValid(resultValid)
  );

  function automatic logic [RES_W-1:0] model(input logic [1:0] op,
      input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input logic [RES_W-1:0] prev);
    logic [RES_W-1:0] x;
    logic [RES_W-1:0] y;
    x = RES_W'(a);
    y = op[1] ? prev : RES_W'(b);
    return op[0] ? RES_W'(x * y) : RES_W'(x + y);
  endfunction

  function automatic string opTag(input logic [1:0] op);
    case (op)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, then check at the next falling edge.
  task automatic issue(input logic v, input logic [1:0] op,
      input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input string tagOverride);
    string tag;
    inValid = v; opcode = op; opA = a; opB = b;
    if (v) expRes = model(op, a, b, expRes);
    tag = (tagOverride != "") ? tagOverride : (v ? opTag(op) : "R6");
    @(negedge clk);
    check(result == expRes, tag, int'(result), int'(expRes));
    check(resultValid == v, "R7", int'(resultValid), int'(v));
  endtask

  task automatic doReset();
    rst = 1'b1; inValid = 1'b1; opcode = 2'b11; opA = 8'hAA; opB = 8'h55;
    @(negedge clk);
    @(negedge clk);
    expRes = '0;
    check(result == '0, "R1", int'(result), 0);
    check(resultValid == 1'b0, "R1", int'(resultValid), 0);
    rst = 1'b0; inValid = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    @(negedge clk);
    doReset();

    // R8: accumulate straight after reset
    issue(1'b1, 2'b10, 8'd5, 8'd200, "R8");
    doReset();
    issue(1'b1, 2'b11, 8'd9, 8'd200, "R8");

    // R2 / R3 extremes
    issue(1'b1, 2'b00, 8'd255, 8'd255, "");
    issue(1'b1, 2'b00, 8'd0, 8'd0, "");
    issue(1'b1, 2'b01, 8'd255, 8'd255, "");
    // R4 wrap past 65535
    for (int i = 0; i < 3; i++) issue(1'b1, 2'b10, 8'd255, 8'd0, "");
    // R6 idle with changing inputs
    for (int i = 0; i < 4; i++) issue(1'b0, 2'(i), 8'(37 * i + 3), 8'(91 * i + 7), "");
    // R5 wrap
    issue(1'b1, 2'b01, 8'd255, 8'd255, "");
    issue(1'b1, 2'b11, 8'd255, 8'd1, "");
    issue(1'b1, 2'b11, 8'd1, 8'd9, "");
    issue(1'b1, 2'b11, 8'd0, 8'd9, "");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic v;
      v = ($urandom % 4) != 0;
      issue(v, 2'($urandom), 8'($urandom), 8'($urandom), "");
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule